// File: doc/BRIEF.md
# Phase-Continuous FSK Carrier Sequencer

This block is the digital oscillator of a two-channel voice-band FSK transmitter. A transmit bit, a channel select and a reduced-rate select pick one of four carrier tones. A phase accumulator clocked from the master clock runs at that tone. Its top four bits walk a sixteen-step phase index through each carrier period. The block brings out a square wave at sixteen times the carrier. It also drives a one-hot pick of one of four magnitude weights plus a sign bit, which steer an external sine-weighted capacitor DAC.

The weights and the sign are refreshed on a strobe from a fixed divider that matches the downstream 192 kHz reconstruction clock. Because of this, the sample rate does not depend on the tone being sent. Changing the tone only changes the accumulator step, so the carrier never jumps in phase. Index i stands for the sample at 11.25 + 22.5·i degrees. Within each half cycle the weight rises 0,1,2,3 and then falls 3,2,1,0. The second half cycle uses the same weights with the sign set.

Top module: `fsk_carrier_seq`

## Requirements
- R1: A synchronous reset clears the accumulator to zero and sets `magSel` to 4'b0001, `negHalf` to 0, `sampleStb` to 0 and `carrierClk16` to 0.
- R2: Each master cycle the accumulator (ACC_W = 24 bits) adds round(f·2^ACC_W / CLK_HZ). On the upper channel (`lowerChan` = 0), f is 1300 Hz when `txData` = 1 and 2100 Hz when `txData` = 0. On the lower channel, f is 390 Hz when `txData` = 1 and 450 Hz when `txData` = 0.
- R3: A change of tone only replaces the step that is added. The accumulator is never reloaded, so the phase index moves by zero or one step per cycle.
- R4: `carrierClk16` is accumulator bit ACC_W-5, which gives sixteen periods per carrier period.
- R5: `sampleStb` is high for one cycle every CLK_HZ/SAMPLE_HZ master cycles (8 with the default parameters). The first strobe comes that many cycles after reset is released or power-down ends.
- R6: On a strobe, the phase index i is the top four accumulator bits before that cycle's add. With j = i[2:0], the weight k is j when j < 4 and 7-j otherwise. `magSel` is then one-hot with bit k set. Between strobes `magSel` holds its value.
- R7: On a strobe `negHalf` takes i[3], so indices 8 to 15 give the negative half cycle.
- R8: `fallback` has no effect on the tone, the phase or any output.
- R9: While `powerDown` is high, the accumulator holds its value, `magSel` and `negHalf` are 0, `sampleStb` is 0 and the divider is cleared. After release, `magSel` stays 0 until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| txData | input | 1 | Bit to send (1 = mark) |
| lowerChan | input | 1 | 1 selects the low-rate lower channel |
| fallback | input | 1 | Reduced-rate select (tone unchanged) |
| powerDown | input | 1 | Freezes phase and silences outputs |
| carrierClk16 | output | 1 | Square wave at 16× carrier |
| magSel | output | 4 | One-hot magnitude weight select |
| negHalf | output | 1 | 1 = negative half cycle |
| sampleStb | output | 1 | One-cycle strobe at the DAC sample rate |

## Verification
The phase-step property assumes that every tone step is below 2^(ACC_W-4), so the index can never skip a position. The bench keeps to the four tones of R2 and the default parameters, where the largest step is about 23 k against a limit of about 1 M. The reduced-rate property assumes that the tone inputs are steady whenever `fallback` toggles. For this reason the bench changes `fallback` only on cycles where `txData` and `lowerChan` do not change. Power-down and reset are applied only at the falling edge, and at arbitrary divider offsets.

// File: rtl/fsk_seq_pkg.sv
package fsk_seq_pkg;

  typedef enum logic [1:0] {
    FQ_UP_MARK  = 2'd0,
    FQ_UP_SPACE = 2'd1,
    FQ_LO_MARK  = 2'd2,
    FQ_LO_SPACE = 2'd3
  } freqSel_e;

  typedef struct packed {
    logic clear;
    logic freeze;
    logic sample;
  } seqStrobes_t;

  function automatic longint unsigned phaseInc(longint unsigned fHz,
                                               longint unsigned clkHz,
                                               int accW);
    return ((fHz << accW) + clkHz / 2) / clkHz;
  endfunction

  // fold the in-half position onto the four weights: 0,1,2,3,3,2,1,0
  function automatic logic [1:0] weightIdx(logic [2:0] pos);
    return pos[2] ? ~pos[1:0] : pos[1:0];
  endfunction

endpackage

// File: rtl/fsk_seq_ctrl.sv
module fsk_seq_ctrl
  import fsk_seq_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        txData,
  input  logic        lowerChan,
  input  logic        powerDown,
  output seqStrobes_t strobes,
  output freqSel_e    freqSel
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst || powerDown) divCnt <= '0;
    else if (divCnt == LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strobes.clear  = rst;
    strobes.freeze = powerDown;
    strobes.sample = !powerDown && (divCnt == LAST);
  end

  always_comb begin
    unique case ({lowerChan, txData})
      2'b01:   freqSel = FQ_UP_MARK;
      2'b00:   freqSel = FQ_UP_SPACE;
      2'b11:   freqSel = FQ_LO_MARK;
      default: freqSel = FQ_LO_SPACE;
    endcase
  end

  generate
    if (DIV > 1) begin : g_gap
      AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        strobes.sample |=> !strobes.sample) else $error("strobe too close"); // R5
    end
  endgenerate

endmodule

// File: rtl/fsk_seq_datapath.sv
module fsk_seq_datapath
  import fsk_seq_pkg::*;
#(
  parameter int              ACC_W    = 24,
  parameter longint unsigned CLK_HZ   = 1536000,
  parameter longint unsigned UP_MARK  = 1300,
  parameter longint unsigned UP_SPACE = 2100,
  parameter longint unsigned LO_MARK  = 390,
  parameter longint unsigned LO_SPACE = 450
) (
  input  logic              clk,
  input  seqStrobes_t       strobes,
  input  freqSel_e          freqSel,
  output logic [ACC_W-1:0]  stepInc,
  output logic              phaseClk,
  output logic [3:0]        magSel,
  output logic              negHalf,
  output logic              sampleStb
);

  localparam int IDX_LSB = ACC_W - 4;
  localparam logic [ACC_W-1:0] INC_UM = ACC_W'(phaseInc(UP_MARK,  CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] INC_US = ACC_W'(phaseInc(UP_SPACE, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] INC_LM = ACC_W'(phaseInc(LO_MARK,  CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] INC_LS = ACC_W'(phaseInc(LO_SPACE, CLK_HZ, ACC_W));

  logic [ACC_W-1:0] phaseAcc;
  logic [3:0]       phaseIdx;
  logic [1:0]       wIdx;
  logic [3:0]       selNext;

  always_comb begin
    unique case (freqSel)
      FQ_UP_MARK:  stepInc = INC_UM;
      FQ_UP_SPACE: stepInc = INC_US;
      FQ_LO_MARK:  stepInc = INC_LM;
      default:     stepInc = INC_LS;
    endcase
  end

  assign phaseIdx = phaseAcc[ACC_W-1:IDX_LSB];
  assign wIdx     = weightIdx(phaseIdx[2:0]);
  assign phaseClk = phaseAcc[ACC_W-5];

  generate
    for (genvar g = 0; g < 4; g++) begin : g_sel
      assign selNext[g] = (wIdx == 2'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      phaseAcc  <= '0;
      magSel    <= 4'b0001;
      negHalf   <= 1'b0;
      sampleStb <= 1'b0;
    end else if (strobes.freeze) begin
      magSel    <= '0;
      negHalf   <= 1'b0;
      sampleStb <= 1'b0;
    end else begin
      phaseAcc  <= phaseAcc + stepInc;
      sampleStb <= strobes.sample;
      if (strobes.sample) begin
        magSel  <= selNext;
        negHalf <= phaseIdx[3];
      end
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.freeze |=> (phaseIdx == $past(phaseIdx)) || (phaseIdx == $past(phaseIdx) + 4'd1))
    else $error("phase index skipped"); // R3

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.freeze |=> $stable(phaseAcc)) else $error("phase moved in power-down"); // R9

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (strobes.clear)
    sampleStb |-> $countones(magSel) == 1) else $error("select not one-hot"); // R6

endmodule

// File: rtl/fsk_carrier_seq.sv
module fsk_carrier_seq
  import fsk_seq_pkg::*;
#(
  parameter int              ACC_W     = 24,
  parameter longint unsigned CLK_HZ    = 1536000,
  parameter longint unsigned SAMPLE_HZ = 192000,
  parameter longint unsigned UP_MARK   = 1300,
  parameter longint unsigned UP_SPACE  = 2100,
  parameter longint unsigned LO_MARK   = 390,
  parameter longint unsigned LO_SPACE  = 450
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txData,
  input  logic       lowerChan,
  input  logic       fallback,
  input  logic       powerDown,
  output logic       carrierClk16,
  output logic [3:0] magSel,
  output logic       negHalf,
  output logic       sampleStb
);

  localparam int DIV = int'(CLK_HZ / SAMPLE_HZ);

  seqStrobes_t      strobes;
  freqSel_e         freqSel;
  logic [ACC_W-1:0] stepInc;

  fsk_seq_ctrl #(.DIV(DIV)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .txData    (txData),
    .lowerChan (lowerChan),
    .powerDown (powerDown),
    .strobes   (strobes),
    .freqSel   (freqSel)
  );

  fsk_seq_datapath #(
    .ACC_W(ACC_W), .CLK_HZ(CLK_HZ),
    .UP_MARK(UP_MARK), .UP_SPACE(UP_SPACE),
    .LO_MARK(LO_MARK), .LO_SPACE(LO_SPACE)
  ) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .freqSel   (freqSel),
    .stepInc   (stepInc),
    .phaseClk  (carrierClk16),
    .magSel    (magSel),
    .negHalf   (negHalf),
    .sampleStb (sampleStb)
  );

  AST_FALLBACK_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
    (!$stable(fallback) && $stable(txData) && $stable(lowerChan)) |-> $stable(stepInc))
    else $error("reduced-rate select moved the tone"); // R8

  AST_QUIET_DOWN: assert property (@(posedge clk) disable iff (rst)
    powerDown |=> (magSel == 4'd0) && !sampleStb && !negHalf) else $error("outputs live in power-down"); // R9

endmodule

// File: tb/fsk_carrier_seq_test.sv
module fsk_carrier_seq_test;
  localparam int              ACC_W  = 24;
  localparam longint unsigned CLK_HZ = 1536000;
  localparam int              DIV    = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, txData = 1'b1, lowerChan = 1'b0, fallback = 1'b0, powerDown = 1'b0;
  logic       carrierClk16, negHalf, sampleStb;
  logic [3:0] magSel;

  fsk_carrier_seq uut (
    .clk(clk), .rst(rst), .txData(txData), .lowerChan(lowerChan),
    .fallback(fallback), .powerDown(powerDown), .carrierClk16(carrierClk16),
    .magSel(magSel), .negHalf(negHalf), .sampleStb(sampleStb)
  );

  typedef struct packed {
    logic       stb;
    logic [3:0] sel;
    logic       neg;
    logic       ck;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    fails  = 0;
  string ctx    = "R1";

  logic [ACC_W-1:0] mAcc = '0;
  int               mCnt = 0;
  logic [3:0]       mSel = 4'b0001;
  logic             mNeg = 1'b0;
  logic             mStb = 1'b0;

  function automatic logic [ACC_W-1:0] incOf(longint unsigned f);
    return ACC_W'(((f << ACC_W) + CLK_HZ / 2) / CLK_HZ);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s, during %s) actual=%0d expected=%0d", req, what, ctx, act, exp);
    end
  endtask

  // driver-side model: runs on the bench's own inputs, pushes the expected outputs
  always @(posedge clk) begin
    longint unsigned f;
    logic [3:0] idx;
    logic [2:0] pos;
    int k;
    if (rst) begin
      mAcc = '0; mCnt = 0; mSel = 4'b0001; mNeg = 1'b0; mStb = 1'b0;
    end else if (powerDown) begin
      mCnt = 0; mSel = 4'b0000; mNeg = 1'b0; mStb = 1'b0;
    end else begin
      f = lowerChan ? (txData ? 390 : 450) : (txData ? 1300 : 2100);   // R2
      if (mCnt == DIV - 1) begin
        idx  = mAcc[ACC_W-1:ACC_W-4];
        pos  = idx[2:0];
        k    = (pos < 4) ? int'(pos) : 7 - int'(pos);
        mSel = 4'(1 << k);
        mNeg = idx[3];
        mStb = 1'b1;
        mCnt = 0;
      end else begin
        mStb = 1'b0;
        mCnt++;
      end
      mAcc = mAcc + incOf(f);
    end
    expQ.push_back('{stb: mStb, sel: mSel, neg: mNeg, ck: mAcc[ACC_W-5]});
  end

  // monitor: compares the design against the queue away from the active edge
  always @(negedge clk) begin
    item_t e;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      check(sampleStb == e.stb, "R5", "sampleStb", sampleStb, e.stb);
      check(magSel == e.sel, e.stb ? "R6" : "R9/R6 hold", "magSel", magSel, e.sel);
      check(negHalf == e.neg, "R7", "negHalf", negHalf, e.neg);
      check(carrierClk16 == e.ck, "R4", "carrierClk16", carrierClk16, e.ck);
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkReset();
    check(magSel == 4'b0001, "R1", "magSel", magSel, 1);
    check(negHalf == 1'b0, "R1", "negHalf", negHalf, 0);
    check(sampleStb == 1'b0, "R1", "sampleStb", sampleStb, 0);
    check(carrierClk16 == 1'b0, "R1", "carrierClk16", carrierClk16, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    hold(3);
    ctx = "R1"; checkReset();
    rst = 1'b0;
    ctx = "R2"; txData = 1'b1; hold(3000);       // upper mark
    txData = 1'b0; hold(3000);                   // upper space
    ctx = "R3";
    for (int c = 0; c < 30; c++) begin txData = ~txData; hold(97); end
    lowerChan = 1'b1;
    for (int c = 0; c < 20; c++) begin txData = ~txData; hold(211); end
    ctx = "R2"; txData = 1'b1; hold(8000);       // lower mark
    txData = 1'b0; hold(8000);                   // lower space
    ctx = "R8"; lowerChan = 1'b0;
    for (int c = 0; c < 20; c++) begin
      hold(1); fallback = ~fallback; hold(70);
      txData = ~txData; hold(80);
    end
    ctx = "R9"; hold(3);
    powerDown = 1'b1; hold(60);
    check(magSel == 4'd0, "R9", "magSel in power-down", magSel, 0);
    powerDown = 1'b0; hold(3);
    check(magSel == 4'd0, "R9", "magSel before first strobe", magSel, 0);
    hold(2000);
    powerDown = 1'b1; hold(5); powerDown = 1'b0; hold(1500);
    ctx = "R1"; rst = 1'b1; hold(2);
    checkReset();
    rst = 1'b0; hold(500);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule